// File: doc/BRIEF.md
# Serial Frame Receiver with Break Recognition

This block receives asynchronous serial frames made of one low start bit, either eight or nine data bits sent least significant bit first, and one high stop bit. The line is sampled on an oversampling tick, sixteen ticks per bit by default. Each bit is decided by a three-sample majority vote taken around its middle. The assembled word is placed in a received data register, and a data-ready flag announces it.

A frame whose stop position reads low is a framing error. If every data bit of such a frame is also zero, the frame is a break character. A break raises both the framing-error flag and data-ready, and it loads zero into the data register. After any low stop bit the receiver waits for the line to return high before it accepts another start bit, so a long break is reported only once.

A frame that completes while data-ready is still set raises the overrun flag, and the older word and its flags are kept. A read strobe clears data-ready, the framing-error flag and the overrun flag. A receiver-active output is high from the detected start edge until the stop position has been sampled.

Top module: `uart_brk_rx`

## Requirements
- R1: After synchronous reset, data_o is 0 and ready_o, ferr_o, ovr_o and busy_o are all 0.
- R2: With nine_bit_i low, a frame of eight data bits (first bit received lands in data_o[0], data_o[8] reads 0) and a high stop bit is stored in data_o with ready_o set and ferr_o clear.
- R3: With nine_bit_i high at the start edge, nine data bits are received, the ninth landing in data_o[8].
- R4: A low stop bit after data that is not all zero sets ferr_o and ready_o, and the received word is still stored in data_o.
- R5: A break (start bit, all data bits zero for the selected format, low stop position) sets ferr_o and ready_o and loads 0 into data_o, in both formats.
- R6: Each bit is decided by a majority of three samples near mid-bit, so a line inversion that lasts a single tick inside a data bit does not change the received value.
- R7: A low level that no longer reads low at the start bit's midpoint is dropped as a glitch: no frame is reported and busy_o returns to 0.
- R8: When a frame completes while ready_o is set and no read is being made, ovr_o is set, and data_o and ferr_o keep the values of the earlier frame.
- R9: A one-cycle pulse on rd_i clears ready_o, ferr_o and ovr_o.
- R10: busy_o is high while a frame is being received and low once its stop position has been sampled; after a low stop bit, no new frame starts until the line has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, OVS ticks per bit |
| nine_bit_i | input | 1 | Format select: 1 for nine data bits, 0 for eight |
| rd_i | input | 1 | Read strobe, clears the status flags |
| data_o | output | 9 | Received data register |
| ready_o | output | 1 | Data-ready flag |
| ferr_o | output | 1 | Framing-error flag |
| ovr_o | output | 1 | Overrun flag |
| busy_o | output | 1 | Receiver active |

## Verification
The hardest case to bring about is a one-tick inversion that falls inside the three-sample vote window of a data bit. The receiver's sampling phase is fixed by the start edge plus a two-flop synchronizer. The stimulus therefore drives every bit for exactly sixteen ticks and inverts the line only on the ninth tick of a chosen bit, which puts the inversion among the voted samples whatever the phase of the tick relative to the clock. Overrun is reached by sending two frames back to back with no read between them. After that the bench checks that the first word and its framing flag survive.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] word;
        logic                stop_ok;
        logic                nine;
    } rx_frame_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic is_break(input rx_frame_t f);
        return !f.stop_ok && (f.word == '0);
    endfunction

endpackage

// File: rtl/uart_brk_sampler.sv
module uart_brk_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic rx_i,
    output logic line_o,
    output logic vote_o
);
    import uart_brk_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
        end
    end

    assign line_o = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '1;
        end else if (tick_i) begin
            win_q <= {win_q[1:0], line_o};
        end
    end

    assign vote_o = vote3(win_q);

endmodule

// File: rtl/uart_brk_framer.sv
module uart_brk_framer #(
    parameter int OVS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick_i,
    input  logic                   line_i,
    input  logic                   vote_i,
    input  logic                   nine_i,
    output logic                   done_o,
    output uart_brk_pkg::rx_frame_t frame_o,
    output logic                   busy_o
);
    import uart_brk_pkg::*;

    localparam int PH_W    = $clog2(OVS);
    localparam int IDX_W   = $clog2(MAX_BITS + 1);
    localparam int VOTE_AT = OVS / 2 + 2;
    localparam logic [PH_W-1:0]  PH_VOTE = PH_W'(VOTE_AT);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_L9  = IDX_W'(MAX_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_L8  = IDX_W'(MAX_BITS - 2);

    rx_state_e           state_q;
    logic [PH_W-1:0]     ph_q;
    logic [IDX_W-1:0]    idx_q;
    logic [MAX_BITS-1:0] sh_q;
    logic                nine_q;
    logic                stop_q;
    logic [IDX_W-1:0]    idx_last;

    assign idx_last = nine_q ? IDX_L9 : IDX_L8;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            nine_q  <= 1'b0;
            stop_q  <= 1'b1;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
                unique case (state_q)
                    ST_IDLE: begin
                        ph_q <= PH_W'(1);
                        if (!line_i) begin
                            state_q <= ST_START;
                            nine_q  <= nine_i;
                            idx_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (ph_q == PH_VOTE && vote_i) begin
                            state_q <= ST_IDLE;
                        end else if (ph_q == PH_LAST) begin
                            state_q <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (ph_q == PH_VOTE) begin
                            sh_q <= {vote_i, sh_q[MAX_BITS-1:1]};
                        end
                        if (ph_q == PH_LAST) begin
                            if (idx_q == idx_last) begin
                                state_q <= ST_STOP;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_STOP: begin
                        if (ph_q == PH_VOTE) begin
                            done_o  <= 1'b1;
                            stop_q  <= vote_i;
                            state_q <= vote_i ? ST_IDLE : ST_HOLD;
                        end
                    end
                    ST_HOLD: begin
                        if (line_i) begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        frame_o.nine    = nine_q;
        frame_o.stop_ok = stop_q;
        frame_o.word    = nine_q ? sh_q : {1'b0, sh_q[MAX_BITS-1:1]};
    end

    assign busy_o = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);

endmodule

// File: rtl/uart_brk_status.sv
module uart_brk_status (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        done_i,
    input  uart_brk_pkg::rx_frame_t     frame_i,
    input  logic                        rd_i,
    output logic [uart_brk_pkg::MAX_BITS-1:0] data_o,
    output logic                        ready_o,
    output logic                        ferr_o,
    output logic                        ovr_o
);
    import uart_brk_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            ready_o <= 1'b0;
            ferr_o  <= 1'b0;
            ovr_o   <= 1'b0;
        end else begin
            if (rd_i) begin
                ready_o <= 1'b0;
                ferr_o  <= 1'b0;
                ovr_o   <= 1'b0;
            end
            if (done_i) begin
                if (ready_o && !rd_i) begin
                    ovr_o <= 1'b1;
                end else begin
                    data_o  <= is_break(frame_i) ? '0 : frame_i.word;
                    ready_o <= 1'b1;
                    ferr_o  <= !frame_i.stop_ok;
                end
            end
        end
    end

endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic       nine_bit_i,
    input  logic       rd_i,
    output logic [8:0] data_o,
    output logic       ready_o,
    output logic       ferr_o,
    output logic       ovr_o,
    output logic       busy_o
);
    import uart_brk_pkg::*;

    logic      line_s;
    logic      vote_s;
    logic      done_s;
    rx_frame_t frame_s;

    uart_brk_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .rx_i   (rx_i),
        .line_o (line_s),
        .vote_o (vote_s)
    );

    uart_brk_framer #(.OVS(OVS)) u_frm (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .line_i  (line_s),
        .vote_i  (vote_s),
        .nine_i  (nine_bit_i),
        .done_o  (done_s),
        .frame_o (frame_s),
        .busy_o  (busy_o)
    );

    uart_brk_status u_sts (
        .clk     (clk),
        .rst     (rst),
        .done_i  (done_s),
        .frame_i (frame_s),
        .rd_i    (rd_i),
        .data_o  (data_o),
        .ready_o (ready_o),
        .ferr_o  (ferr_o),
        .ovr_o   (ovr_o)
    );

endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_i,
    input logic [8:0] data_o,
    input logic       ready_o,
    input logic       ferr_o,
    input logic       ovr_o,
    input logic       busy_o
);
    // R8: an unread word is never overwritten
    a_r8_data_kept: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !rd_i) |=> $stable(data_o));

    // R8: overrun only arises while a word is waiting
    a_r8_ovr_after_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> $past(ready_o));

    // R9: a read leaves no overrun behind
    a_r9_read_clears_ovr: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> !ovr_o);

    // R4: framing error is only reported together with a stored word
    a_r4_ferr_has_ready: assert property (@(posedge clk) disable iff (rst)
        ferr_o |-> ready_o);

    // R10: a frame is reported only after the receiver has gone inactive
    a_r10_idle_at_report: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> !busy_o);

    // R1: flags are clear right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!ready_o && !ferr_o && !ovr_o && !busy_o));
endmodule

bind uart_brk_rx uart_brk_rx_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_i),
    .data_o  (data_o),
    .ready_o (ready_o),
    .ferr_o  (ferr_o),
    .ovr_o   (ovr_o),
    .busy_o  (busy_o)
);

// File: tb/sim_uart_brk_rx.sv
module sim_uart_brk_rx;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS_BIT  = 16;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic       nine;
        logic [8:0] word;
        logic       stop;
        logic [8:0] exp_data;
        logic       exp_ferr;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 9'h0A5, 1'b1, 9'h0A5, 1'b0},
        '{1'b0, 9'h000, 1'b1, 9'h000, 1'b0},
        '{1'b0, 9'h0FF, 1'b1, 9'h0FF, 1'b0},
        '{1'b0, 9'h03C, 1'b0, 9'h03C, 1'b1},
        '{1'b0, 9'h000, 1'b0, 9'h000, 1'b1},
        '{1'b1, 9'h1FF, 1'b1, 9'h1FF, 1'b0},
        '{1'b1, 9'h100, 1'b1, 9'h100, 1'b0},
        '{1'b1, 9'h100, 1'b0, 9'h100, 1'b1},
        '{1'b1, 9'h155, 1'b0, 9'h155, 1'b1},
        '{1'b1, 9'h000, 1'b0, 9'h000, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       nine_bit_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [8:0] data_o;
    logic       ready_o, ferr_o, ovr_o, busy_o;

    int n_chk = 0;
    int n_fail = 0;
    logic busy_mid;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) tick_i <= rst ? 1'b0 : ~tick_i;

    uart_brk_rx u0 (
        .clk(clk), .rst(rst), .rx_i(rx_i), .tick_i(tick_i),
        .nine_bit_i(nine_bit_i), .rd_i(rd_i), .data_o(data_o),
        .ready_o(ready_o), .ferr_o(ferr_o), .ovr_o(ovr_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic glitch);
        for (int t = 0; t < TICKS_BIT; t++) begin
            rx_i = (glitch && t == 8) ? ~b : b;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic nine, input logic [8:0] word,
                              input logic stop, input logic [8:0] gmask);
        nine_bit_i = nine;
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            send_bit(word[i], gmask[i]);
            if (i == 2) busy_mid = busy_o;
        end
        send_bit(stop, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
    endtask

    task automatic do_read();
        @(negedge clk) rd_i = 1'b1;
        @(negedge clk) rd_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 data", data_o, 9'h000);
        check("R1 ready", {8'h0, ready_o}, 9'h0);
        check("R1 ferr", {8'h0, ferr_o}, 9'h0);
        check("R1 ovr", {8'h0, ovr_o}, 9'h0);
        check("R1 busy", {8'h0, busy_o}, 9'h0);
        repeat (40) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            string tag;
            if (VECS[v].exp_ferr && VECS[v].word == 9'h0) tag = "R5";
            else if (VECS[v].exp_ferr) tag = "R4";
            else if (VECS[v].nine) tag = "R3";
            else tag = "R2";
            send_frame(VECS[v].nine, VECS[v].word, VECS[v].stop, 9'h0);
            check({tag, " data"}, data_o, VECS[v].exp_data);
            check({tag, " ready"}, {8'h0, ready_o}, 9'h1);
            check({tag, " ferr"}, {8'h0, ferr_o}, {8'h0, VECS[v].exp_ferr});
            check({tag, " ovr"}, {8'h0, ovr_o}, 9'h0);
            check("R10 busy mid-frame", {8'h0, busy_mid}, 9'h1);
            check("R10 busy after frame", {8'h0, busy_o}, 9'h0);
            do_read();
            check("R9 ready cleared", {8'h0, ready_o}, 9'h0);
            check("R9 ferr cleared", {8'h0, ferr_o}, 9'h0);
        end

        // R6: one-tick inversion inside every data bit
        send_frame(1'b0, 9'h0C3, 1'b1, 9'h0FF);
        check("R6 glitched bits", data_o, 9'h0C3);
        check("R6 ferr", {8'h0, ferr_o}, 9'h0);
        do_read();

        // R7: short low pulse is not a start bit
        rx_i = 1'b0;
        repeat (8) @(negedge clk);
        rx_i = 1'b1;
        repeat (3 * TICKS_BIT * 2) @(negedge clk);
        check("R7 no frame", {8'h0, ready_o}, 9'h0);
        check("R7 busy idle", {8'h0, busy_o}, 9'h0);

        // R8: second frame without read
        send_frame(1'b0, 9'h05A, 1'b0, 9'h0);
        send_frame(1'b0, 9'h0E7, 1'b1, 9'h0);
        check("R8 ovr set", {8'h0, ovr_o}, 9'h1);
        check("R8 old data kept", data_o, 9'h05A);
        check("R8 old ferr kept", {8'h0, ferr_o}, 9'h1);
        check("R8 ready held", {8'h0, ready_o}, 9'h1);
        do_read();
        check("R9 ovr cleared", {8'h0, ovr_o}, 9'h0);
        check("R9 ready cleared after ovr", {8'h0, ready_o}, 9'h0);

        // R10: long break reported once, then a new frame after line goes high
        nine_bit_i = 1'b0;
        rx_i = 1'b0;
        repeat (20 * TICKS_BIT * 2) @(negedge clk);
        check("R5 long break data", data_o, 9'h000);
        check("R5 long break ferr", {8'h0, ferr_o}, 9'h1);
        check("R10 hold not busy", {8'h0, busy_o}, 9'h0);
        do_read();
        repeat (6 * TICKS_BIT * 2) @(negedge clk);
        check("R10 no second break", {8'h0, ready_o}, 9'h0);
        rx_i = 1'b1;
        repeat (2 * TICKS_BIT * 2) @(negedge clk);
        send_frame(1'b0, 9'h081, 1'b1, 9'h0);
        check("R10 frame after hold", data_o, 9'h081);
        check("R10 ready after hold", {8'h0, ready_o}, 9'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule